// File: doc/BRIEF.md
# Auto-incrementing endpoint FIFO port

This block holds two 8-byte buffers that a microcontroller reaches through one data address each. Lane 0 serves endpoint 0. Lane 1 is shared by endpoints 1 to 3. Each lane has a 3-bit circular pointer. Every CPU access to a lane's data address reads or writes the byte at that pointer and then moves the pointer one step forward. After index 7 the pointer wraps to 0.

A third address is a buffer-control register. Writing a 1 to one of its bits sets the matching lane's pointer back to 0.

Two inputs gate the CPU side:
- `rx_disable` blocks CPU writes into the endpoint-0 lane.
- `ep_sel` routes the shared lane. When it names no endpoint, the shared lane does not respond.

The USB side reads either lane through its own byte index. This index never touches the CPU pointers.

Top module: `epfifo_port`

## Requirements
- R1: After reset every byte of both lanes is 00h and both pointers are 0. A CPU read of either data address returns 00h, and the USB read ports return 00h at every index.
- R2: A CPU write (`cpu_wr`=1) to the lane-0 data address (`cpu_addr`=0) stores `cpu_wdata` at the lane-0 pointer and advances that pointer by one.
- R3: A CPU read (`cpu_rd`=1) of a data address shows the byte at that lane's pointer on `cpu_rdata` in the same cycle. The pointer advances by one at the following clock edge.
- R4: Both pointers wrap from 7 to 0, so a ninth consecutive write overwrites index 0.
- R5: A CPU write to the control address (`cpu_addr`=2) resets the lane-0 pointer when `cpu_wdata` bit 0 is 1, and the lane-1 pointer when bit 1 is 1. A 0 in either bit leaves that pointer unchanged. A reset of one lane does not move the other lane's pointer.
- R6: A CPU read of the control address returns 00h. Address 3 also reads as 00h.
- R7: While `rx_disable`=1, a CPU write to the lane-0 data address leaves the stored byte unchanged, but the lane-0 pointer still advances.
- R8: The lane-1 data address (`cpu_addr`=1) responds only when `ep_sel` is nonzero (endpoints 1 to 3). With `ep_sel`=0, an access there returns 00h, stores nothing and does not move the lane-1 pointer.
- R9: The USB read ports `usb_ep0_byte` and `usb_shr_byte` show, combinationally, the byte at index `usb_idx` of their lane. They never move a CPU pointer.
- R10: When `cpu_rd` and `cpu_wr` are both 1 in one cycle, `cpu_rdata` shows the old byte, the new byte is stored at that index, and the pointer advances exactly once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 2 | 0 = lane-0 data, 1 = lane-1 data, 2 = control, 3 = unused |
| cpu_rd | input | 1 | CPU read strobe, one access per cycle |
| cpu_wr | input | 1 | CPU write strobe, one access per cycle |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data, combinational, 00h when not reading |
| rx_disable | input | 1 | Blocks CPU writes into lane 0 |
| ep_sel | input | 2 | Endpoint select for the shared lane, 0 = none |
| usb_idx | input | 3 | USB-side byte index |
| usb_ep0_byte | output | 8 | Lane-0 byte at `usb_idx` |
| usb_shr_byte | output | 8 | Lane-1 byte at `usb_idx` |

## Verification
Read data and USB bytes are combinational, so they are due in the cycle of the stimulus. Writes, pointer moves and pointer resets become visible from the next cycle on.

The bench drives inputs one nanosecond after a rising edge and samples at the falling edge of the same cycle. Each read therefore checks the byte selected by the pointer state left by all earlier cycles.

A blocked write, a pointer reset and an ignored shared-lane access are observed through the sequence of later reads and USB-port bytes. Those reads and bytes reveal both where each pointer stands and whether a byte was stored.

// File: rtl/epf_pkg.sv
// Shared constants for the endpoint FIFO port: CPU address codes and
// the control-register bit positions that select which pointer to reset.
package epf_pkg;
    localparam logic [1:0] ADDR_EP0  = 2'd0;
    localparam logic [1:0] ADDR_SHR  = 2'd1;
    localparam logic [1:0] ADDR_CTL  = 2'd2;
    localparam int         CLR_EP0   = 0;
    localparam int         CLR_SHR   = 1;
    localparam int         NUM_LANES = 2;
endpackage

// File: rtl/epf_ptr.sv
// Circular access pointer for one lane.
// Assumes DEPTH is a power of two, so the natural overflow wraps it.
// A clear has priority over a step in the same cycle.
module epf_ptr #(
    parameter int DEPTH = 8,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          step,
    output logic [PW-1:0] ptr
);
    // Pointer register: reset or clear to 0, otherwise step by one.
    always_ff @(posedge clk) begin
        if (!rst_n)     ptr <= '0;
        else if (clr)   ptr <= '0;
        else if (step)  ptr <= ptr + 1'b1;
    end
endmodule

// File: rtl/epf_store.sv
// Byte storage for one lane: one write port and two combinational read
// ports (CPU side and USB side). Every byte resets to zero.
module epf_store #(
    parameter int DW    = 8,
    parameter int DEPTH = 8,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [PW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [PW-1:0] raddr_a,
    output logic [DW-1:0] rdata_a,
    input  logic [PW-1:0] raddr_b,
    output logic [DW-1:0] rdata_b
);
    logic [DW-1:0] mem [DEPTH];

    // Storage array: cleared by reset, one byte written per enabled cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Read ports: plain combinational lookups.
    always_comb begin
        rdata_a = mem[raddr_a];
        rdata_b = mem[raddr_b];
    end
endmodule

// File: rtl/epf_lane.sv
// One FIFO lane: pointer plus storage. The CPU port writes at and reads
// from the pointer. The USB port reads at an external index that never
// disturbs the pointer.
module epf_lane #(
    parameter int DW    = 8,
    parameter int DEPTH = 8,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          access,
    input  logic          we,
    input  logic [DW-1:0] wdata,
    input  logic [PW-1:0] usb_idx,
    output logic [DW-1:0] cpu_byte,
    output logic [DW-1:0] usb_byte,
    output logic [PW-1:0] ptr
);
    epf_ptr #(.DEPTH(DEPTH)) u_ptr (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (clr),
        .step (access),
        .ptr  (ptr)
    );

    epf_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (we),
        .waddr  (ptr),
        .wdata  (wdata),
        .raddr_a(ptr),
        .rdata_a(cpu_byte),
        .raddr_b(usb_idx),
        .rdata_b(usb_byte)
    );
endmodule

// File: rtl/epfifo_port.sv
// Endpoint FIFO port top.
// Decodes the CPU address into two lanes and a write-only control
// register. It gates lane-0 writes with rx_disable and routes lane 1
// only while ep_sel names an endpoint.
// Assumes at most one CPU access per cycle. rd and wr together count as
// one access that both reads the old byte and writes the new one.
module epfifo_port #(
    parameter int DW    = 8,
    parameter int DEPTH = 8,
    parameter int SELW  = 2,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      cpu_addr,
    input  logic            cpu_rd,
    input  logic            cpu_wr,
    input  logic [DW-1:0]   cpu_wdata,
    output logic [DW-1:0]   cpu_rdata,
    input  logic            rx_disable,
    input  logic [SELW-1:0] ep_sel,
    input  logic [PW-1:0]   usb_idx,
    output logic [DW-1:0]   usb_ep0_byte,
    output logic [DW-1:0]   usb_shr_byte
);
    import epf_pkg::*;

    logic                          any_access;
    logic                          ctl_wr;
    logic [NUM_LANES-1:0]          lane_hit;
    logic [NUM_LANES-1:0]          lane_we;
    logic [NUM_LANES-1:0]          lane_clr;
    logic [NUM_LANES-1:0][DW-1:0]  lane_cpu_byte;
    logic [NUM_LANES-1:0][DW-1:0]  lane_usb_byte;
    logic [NUM_LANES-1:0][PW-1:0]  lane_ptr;

    // Address decode: lane hits, write gating and pointer-clear strobes.
    always_comb begin
        any_access     = cpu_rd | cpu_wr;
        ctl_wr         = cpu_wr && (cpu_addr == ADDR_CTL);
        lane_hit[0]    = any_access && (cpu_addr == ADDR_EP0);
        lane_hit[1]    = any_access && (cpu_addr == ADDR_SHR) && (ep_sel != '0);
        lane_we[0]     = lane_hit[0] && cpu_wr && !rx_disable;
        lane_we[1]     = lane_hit[1] && cpu_wr;
        lane_clr[0]    = ctl_wr && cpu_wdata[CLR_EP0];
        lane_clr[1]    = ctl_wr && cpu_wdata[CLR_SHR];
    end

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        epf_lane #(.DW(DW), .DEPTH(DEPTH)) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (lane_clr[g]),
            .access  (lane_hit[g]),
            .we      (lane_we[g]),
            .wdata   (cpu_wdata),
            .usb_idx (usb_idx),
            .cpu_byte(lane_cpu_byte[g]),
            .usb_byte(lane_usb_byte[g]),
            .ptr     (lane_ptr[g])
        );
    end

    // CPU read mux: a lane byte on a live hit, zero otherwise.
    always_comb begin
        cpu_rdata = '0;
        if (cpu_rd) begin
            if (lane_hit[0])      cpu_rdata = lane_cpu_byte[0];
            else if (lane_hit[1]) cpu_rdata = lane_cpu_byte[1];
        end
    end

    // USB read ports: straight from each lane.
    always_comb begin
        usb_ep0_byte = lane_usb_byte[0];
        usb_shr_byte = lane_usb_byte[1];
    end
endmodule

// File: rtl/epfifo_port_chk.sv
// Property checker for epfifo_port, bound to every instance.
// It watches the CPU port and the two lane pointers.
module epfifo_port_chk #(
    parameter int DW    = 8,
    parameter int DEPTH = 8,
    parameter int SELW  = 2,
    localparam int PW   = $clog2(DEPTH)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [1:0]            cpu_addr,
    input logic                  cpu_rd,
    input logic                  cpu_wr,
    input logic [DW-1:0]         cpu_wdata,
    input logic [DW-1:0]         cpu_rdata,
    input logic [SELW-1:0]       ep_sel,
    input logic [1:0][PW-1:0]    lane_ptr
);
    logic ep0_acc, shr_acc, ctl_w;
    assign ep0_acc = (cpu_rd || cpu_wr) && cpu_addr == 2'd0;
    assign shr_acc = (cpu_rd || cpu_wr) && cpu_addr == 2'd1;
    assign ctl_w   = cpu_wr && cpu_addr == 2'd2;

    AST_EP0_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ep0_acc |=> lane_ptr[0] == PW'($past(lane_ptr[0]) + 1'b1)); // R2
    AST_EP0_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_w && cpu_wdata[0]) |=> lane_ptr[0] == '0); // R5
    AST_SHR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_w && cpu_wdata[1]) |=> lane_ptr[1] == '0); // R5
    AST_SHR_UNSEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (shr_acc && ep_sel == '0) |=> $stable(lane_ptr[1])); // R8
    AST_CTL_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && cpu_addr[1]) |-> cpu_rdata == '0); // R6
    AST_EP0_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ep0_acc && !(ctl_w && cpu_wdata[0])) |=> $stable(lane_ptr[0])); // R9
endmodule

bind epfifo_port epfifo_port_chk #(.DW(DW), .DEPTH(DEPTH), .SELW(SELW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_addr (cpu_addr),
    .cpu_rd   (cpu_rd),
    .cpu_wr   (cpu_wr),
    .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata),
    .ep_sel   (ep_sel),
    .lane_ptr (lane_ptr)
);

// File: tb/epfifo_port_bench.sv
`timescale 1ns/1ps
module epfifo_port_bench;
    logic       clk = 0;
    logic       rst_n = 0;
    logic [1:0] cpu_addr = 0;
    logic       cpu_rd = 0, cpu_wr = 0;
    logic [7:0] cpu_wdata = 0;
    logic [7:0] cpu_rdata;
    logic       rx_disable = 0;
    logic [1:0] ep_sel = 0;
    logic [2:0] usb_idx = 0;
    logic [7:0] usb_ep0_byte, usb_shr_byte;

    always #2 clk = ~clk;

    epfifo_port u_epfifo_port (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
        .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .rx_disable(rx_disable), .ep_sel(ep_sel), .usb_idx(usb_idx),
        .usb_ep0_byte(usb_ep0_byte), .usb_shr_byte(usb_shr_byte)
    );

    typedef struct {
        int         kind;
        logic [7:0] exp;
        string      tag;
    } item_t;

    item_t      sb_q[$];
    logic       chk_valid = 0;
    int         checks = 0;
    int         failures = 0;
    bit         done = 0;
    logic [7:0] m [2][8];
    logic [2:0] p [2];

    // Driver for one CPU cycle: computes the expected read, queues it, updates the model.
    task automatic cpu(input logic [1:0] a, input bit rd, input bit wr,
                       input logic [7:0] d, input logic [1:0] sel,
                       input bit rxd, input string tag);
        logic [7:0] e;
        item_t it;
        @(posedge clk); #1;
        cpu_addr = a; cpu_rd = rd; cpu_wr = wr; cpu_wdata = d;
        ep_sel = sel; rx_disable = rxd;
        e = 8'h00;
        if (a == 2'd0) e = m[0][p[0]];
        else if (a == 2'd1 && sel != 0) e = m[1][p[1]];
        chk_valid = rd;
        if (rd) begin
            it.kind = 0; it.exp = e; it.tag = tag;
            sb_q.push_back(it);
        end
        if (a == 2'd0 && (rd || wr)) begin
            if (wr && !rxd) m[0][p[0]] = d;
            p[0] = p[0] + 1;
        end else if (a == 2'd1 && (rd || wr) && sel != 0) begin
            if (wr) m[1][p[1]] = d;
            p[1] = p[1] + 1;
        end else if (a == 2'd2 && wr) begin
            if (d[0]) p[0] = 0;
            if (d[1]) p[1] = 0;
        end
    endtask

    // Driver for a USB-side check of one lane at one index, with the CPU idle.
    task automatic usb(input int lane, input logic [2:0] idx, input string tag);
        item_t it;
        @(posedge clk); #1;
        cpu_rd = 0; cpu_wr = 0; usb_idx = idx;
        chk_valid = 1;
        it.kind = 1 + lane; it.exp = m[lane][idx]; it.tag = tag;
        sb_q.push_back(it);
    endtask

    // Monitor: pops and compares at the falling edge of every flagged cycle.
    always @(negedge clk) begin
        if (rst_n && chk_valid && !done) begin
            item_t it;
            logic [7:0] act;
            checks++;
            if (sb_q.size() == 0) begin
                failures++;
                $display("FAIL scoreboard empty actual=none expected=item");
            end else begin
                it = sb_q.pop_front();
                act = (it.kind == 0) ? cpu_rdata :
                      (it.kind == 1) ? usb_ep0_byte : usb_shr_byte;
                if (act !== it.exp) begin
                    failures++;
                    $display("FAIL %s kind=%0d actual=%02h expected=%02h",
                             it.tag, it.kind, act, it.exp);
                end
            end
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(4 * 150000);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int l = 0; l < 2; l++) begin
            p[l] = 0;
            for (int i = 0; i < 8; i++) m[l][i] = 8'h00;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1: reset state through both read paths
        cpu(2'd0, 1, 0, 8'h00, 2'd1, 0, "R1");
        cpu(2'd1, 1, 0, 8'h00, 2'd1, 0, "R1");
        usb(0, 3'd5, "R1");
        usb(1, 3'd2, "R1");
        cpu(2'd2, 0, 1, 8'h03, 2'd1, 0, "R5");
        // R2: fill lane 0, then R4: the ninth write wraps onto index 0
        for (int i = 0; i < 8; i++) cpu(2'd0, 0, 1, 8'h10 + 8'(i), 2'd1, 0, "R2");
        cpu(2'd0, 0, 1, 8'hAA, 2'd1, 0, "R4");
        cpu(2'd2, 0, 1, 8'h01, 2'd1, 0, "R5");
        cpu(2'd0, 1, 0, 8'h00, 2'd1, 0, "R4");
        for (int i = 1; i < 8; i++) cpu(2'd0, 1, 0, 8'h00, 2'd1, 0, "R3");
        // R7: a blocked write still moves the pointer
        cpu(2'd0, 0, 1, 8'h55, 2'd1, 1, "R7");
        cpu(2'd0, 1, 0, 8'h00, 2'd1, 0, "R7");
        usb(0, 3'd0, "R7");
        // R8: shared lane routed only while ep_sel is nonzero
        for (int i = 0; i < 3; i++) cpu(2'd1, 0, 1, 8'h21 + 8'(i), 2'd2, 0, "R8");
        cpu(2'd1, 0, 1, 8'h99, 2'd0, 0, "R8");
        cpu(2'd1, 1, 0, 8'h00, 2'd0, 0, "R8");
        usb(1, 3'd3, "R8");
        cpu(2'd1, 0, 1, 8'h88, 2'd3, 0, "R8");
        usb(1, 3'd3, "R8");
        // R5: clear only the shared pointer, then a write of 0 changes nothing
        cpu(2'd2, 0, 1, 8'h02, 2'd3, 0, "R5");
        for (int i = 0; i < 4; i++) cpu(2'd1, 1, 0, 8'h00, 2'd3, 0, "R5");
        cpu(2'd0, 1, 0, 8'h00, 2'd1, 0, "R5");
        cpu(2'd2, 0, 1, 8'h00, 2'd1, 0, "R5");
        cpu(2'd0, 1, 0, 8'h00, 2'd1, 0, "R5");
        // R6: control and unused addresses read as zero
        cpu(2'd2, 1, 0, 8'h00, 2'd1, 0, "R6");
        cpu(2'd3, 1, 0, 8'h00, 2'd1, 0, "R6");
        // R10: read and write in one cycle
        cpu(2'd0, 1, 1, 8'h77, 2'd1, 0, "R10");
        cpu(2'd0, 1, 0, 8'h00, 2'd1, 0, "R10");
        cpu(2'd2, 0, 1, 8'h01, 2'd1, 0, "R10");
        for (int i = 0; i < 6; i++) cpu(2'd0, 1, 0, 8'h00, 2'd1, 0, "R10");
        // R9: sweep the USB index, then confirm the CPU pointer did not move
        for (int i = 0; i < 8; i++) begin
            usb(0, 3'(i), "R9");
            usb(1, 3'(i), "R9");
        end
        cpu(2'd0, 1, 0, 8'h00, 2'd1, 0, "R9");
        cpu(2'd1, 1, 0, 8'h00, 2'd1, 0, "R9");
        @(posedge clk); #1;
        cpu_rd = 0; cpu_wr = 0; chk_valid = 0;
        repeat (2) @(posedge clk);
        if (sb_q.size() != 0) begin
            checks++;
            failures++;
            $display("FAIL scoreboard leftover actual=%0d expected=0", sb_q.size());
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule